// File: doc/BRIEF.md
# Non-Maskable Interrupt Aggregator

The block gathers five non-maskable interrupt sources into a single request line toward the CPU. The sources are an external interrupt pin, an oscillator-stop detector, a watchdog underflow or refresh-error flag, and two supply-voltage monitors. Every source owns a sticky status flag. A flag is set by its source's event and is cleared only when software writes a one to that source's bit in a write-one-to-clear register. A source may drive the combined request only after software has set its bit in a write-once enable register. The request takes no account of the CPU's interrupt-enable and priority-level inputs.

The pin path has its own conditioning stage. It runs through an optional digital noise filter that samples at a divided clock rate and accepts a new level only after three samples in a row agree. After the filter, a detector fires on either the rising or the falling edge, as selected. The pin configuration can be rewritten at run time. A rewrite holds the edge detector quiet for a short window, so that a reconfiguration cannot create an event of its own.

A small register port reaches four locations: the enable register, the clear register, the status register and the pin configuration register. Reads are combinational.

Top module: `nmi_aggr`

## Requirements
- R1: The status register (address 2) holds one flag per source, bit 0 pin, bit 1 oscillator stop, bit 2 watchdog, bit 3 voltage monitor A, bit 4 voltage monitor B. A one-cycle event sets the flag whether or not the source is enabled, and the flag then stays set.
- R2: After reset the enable register (address 0) and the status register read 0 and the request is low. A flag whose enable bit is 0 never raises the request.
- R3: Writing 1 to an enable bit sets it. Any later write that carries 0 for that bit leaves it at 1 until reset.
- R4: Writing 1 to a bit of the clear register (address 1) clears that flag in the next cycle. A 0 in the written data leaves the flag unchanged. The clear register reads back as 0.
- R5: Pin configuration (address 3) bit 0 selects the pin edge: 0 means falling, 1 means rising. An edge of the opposite direction sets no flag.
- R6: Pin configuration bit 1 enables the filter, and bits 3:2 select a sample period of 1, 8, 32 or 64 clocks. With the filter on, a pin change reaches the status flag between 2D+2 and 3D+1 clocks after it is applied (D is the period). A pulse of 2 clocks is rejected.
- R7: With the filter off, a pin edge sets the pin status flag on the second clock edge after the pin changes.
- R8: The request does not depend on the CPU interrupt-enable or priority-level inputs.
- R9: The request is high exactly while at least one flag is set whose source is enabled. Clearing one flag keeps the request high while another enabled flag remains set.
- R10: When a source event and a clear of that same flag land in the same cycle, the flag ends set.
- R11: A write to the pin configuration reloads the edge history and suppresses pin events for that cycle and the two after it. Disabling the filter while the pin is already held at its active level sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 1 | External interrupt pin level |
| osc_stop_evt | input | 1 | Oscillator-stop event pulse |
| wdt_err_evt | input | 1 | Watchdog underflow/refresh-error pulse |
| vmon1_evt | input | 1 | Voltage monitor A event pulse |
| vmon2_evt | input | 1 | Voltage monitor B event pulse |
| cpu_ie | input | 1 | CPU interrupt-enable state (no effect on the request) |
| cpu_ipl | input | 4 | CPU priority level (no effect on the request) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 5 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 5 | Register read data (combinational) |
| nmi_req | output | 1 | Combined non-maskable request |

## Verification
A source event and a software clear of the same flag can reach the status bank in the same clock cycle. The bench provokes this by raising each non-pin source in the cycle that carries the clear write. The flag must still read as set afterwards, and the bench then clears it on its own to confirm the clear path still works. A second overlap, a pin-configuration write arriving while the pin already sits at its active level, is judged by reading the pin flag, which must stay 0.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
  localparam int unsigned NSRC = 5;

  localparam int unsigned SRC_PIN  = 0;
  localparam int unsigned SRC_OSC  = 1;
  localparam int unsigned SRC_WDT  = 2;
  localparam int unsigned SRC_VM1  = 3;
  localparam int unsigned SRC_VM2  = 4;

  typedef enum logic [1:0] {
    REG_ENABLE = 2'd0,
    REG_CLEAR  = 2'd1,
    REG_STATUS = 2'd2,
    REG_PINCFG = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [1:0] sel;      // sample-period select
    logic       filt_en;  // noise filter on
    logic       rising;   // 1: rising edge, 0: falling edge
  } pincfg_t;

  // Sample period in clocks for each select code.
  function automatic int unsigned div_of(input logic [1:0] sel);
    case (sel)
      2'd0:    div_of = 1;
      2'd1:    div_of = 8;
      2'd2:    div_of = 32;
      default: div_of = 64;
    endcase
  endfunction
endpackage

// File: rtl/nmi_pin_filter.sv
module nmi_pin_filter import nmi_pkg::*; #(
  parameter int unsigned MAX_DIV  = 64,
  parameter logic        IDLE_LVL = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic       en,
  input  logic [1:0] sel,
  input  logic       restart,
  output logic       lvl,
  output logic       tick
);
  localparam int unsigned CNT_W = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic [1:0]       hist;   // hist[0] newest sample
  logic             agree;

  assign lim   = CNT_W'(div_of(sel) - 1);
  assign tick  = en && !restart && (cnt == lim);
  assign agree = (pin == hist[0]) && (pin == hist[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      hist <= {2{IDLE_LVL}};
      lvl  <= IDLE_LVL;
    end else if (restart) begin
      cnt  <= '0;
      hist <= {2{lvl}};
    end else if (!en) begin
      cnt  <= '0;
      hist <= {2{pin}};
      lvl  <= pin;
    end else if (tick) begin
      cnt  <= '0;
      hist <= {hist[0], pin};
      if (agree) lvl <= pin;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6: between sample ticks the filtered level does not move
  p_hold_between_ticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(lvl));
endmodule

// File: rtl/nmi_edge_det.sv
module nmi_edge_det #(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic rising,
  input  logic hold,
  output logic hit
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= IDLE_LVL;
    else        prev <= lvl;   // reload from current level, also during hold
  end

  assign hit = !hold && (rising ? (lvl && !prev) : (!lvl && prev));

  // R5: a reported edge always ends at the selected active level
  p_edge_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (lvl == rising));
endmodule

// File: rtl/nmi_status_bank.sv
module nmi_status_bank #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] st
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      st[i] <= 1'b0;
      else if (evt[i]) st[i] <= 1'b1;
      else if (clr[i]) st[i] <= 1'b0;
    end
  end

  // R10: an event always leaves its flag set, even with a clear
  p_evt_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((st & $past(evt)) == $past(evt)));
  // R4: a clear without an event empties the flag
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~evt)) |=> ((st & $past(clr & ~evt)) == '0));
  // R1: flags are sticky without a clear
  p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (clr == '0) |=> ((st & $past(st)) == $past(st)));
endmodule

// File: rtl/nmi_aggr.sv
module nmi_aggr import nmi_pkg::*; #(
  parameter int unsigned MAX_DIV  = 64,
  parameter logic        IDLE_LVL = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pin_in,
  input  logic            osc_stop_evt,
  input  logic            wdt_err_evt,
  input  logic            vmon1_evt,
  input  logic            vmon2_evt,
  input  logic            cpu_ie,
  input  logic [3:0]      cpu_ipl,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [NSRC-1:0] wr_data,
  input  logic [1:0]      rd_addr,
  output logic [NSRC-1:0] rd_data,
  output logic            nmi_req
);
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] st_q;
  logic [NSRC-1:0] evt_vec;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] set_vec;
  pincfg_t         cfg_q;
  logic            cfg_wr, cfg_wr_q, cfg_wr_qq, cfg_hold;
  logic            filt_lvl, filt_tick, pin_evt;

  assign cfg_wr  = wr_en && (wr_addr == REG_PINCFG);
  assign set_vec = (wr_en && (wr_addr == REG_ENABLE)) ? wr_data : '0;
  assign clr_vec = (wr_en && (wr_addr == REG_CLEAR))  ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= '0;
      cfg_q     <= '0;
      cfg_wr_q  <= 1'b0;
      cfg_wr_qq <= 1'b0;
    end else begin
      en_q      <= en_q | set_vec;
      cfg_wr_q  <= cfg_wr;
      cfg_wr_qq <= cfg_wr_q;
      if (cfg_wr) cfg_q <= pincfg_t'(wr_data[3:0]);
    end
  end

  assign cfg_hold = cfg_wr | cfg_wr_q | cfg_wr_qq;

  nmi_pin_filter #(.MAX_DIV(MAX_DIV), .IDLE_LVL(IDLE_LVL)) filt_i (
    .clk(clk), .rst_n(rst_n), .pin(pin_in), .en(cfg_q.filt_en),
    .sel(cfg_q.sel), .restart(cfg_wr), .lvl(filt_lvl), .tick(filt_tick));

  nmi_edge_det #(.IDLE_LVL(IDLE_LVL)) edge_i (
    .clk(clk), .rst_n(rst_n), .lvl(filt_lvl), .rising(cfg_q.rising),
    .hold(cfg_hold), .hit(pin_evt));

  always_comb begin
    evt_vec          = '0;
    evt_vec[SRC_PIN] = pin_evt;
    evt_vec[SRC_OSC] = osc_stop_evt;
    evt_vec[SRC_WDT] = wdt_err_evt;
    evt_vec[SRC_VM1] = vmon1_evt;
    evt_vec[SRC_VM2] = vmon2_evt;
  end

  nmi_status_bank #(.N(NSRC)) bank_i (
    .clk(clk), .rst_n(rst_n), .evt(evt_vec), .clr(clr_vec), .st(st_q));

  assign nmi_req = |(st_q & en_q);

  always_comb begin
    case (reg_addr_e'(rd_addr))
      REG_ENABLE: rd_data = en_q;
      REG_STATUS: rd_data = st_q;
      REG_PINCFG: rd_data = {1'b0, cfg_q};
      default:    rd_data = '0;
    endcase
  end

  // R3: enable bits never fall once set
  p_enable_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((en_q & $past(en_q)) == $past(en_q)));
  // R2: nothing enabled, no request
  p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !nmi_req);
  // R8: masked CPU state cannot hold back a pending request
  p_mask_indep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_ie && (cpu_ipl == 4'hF) && (|(st_q & en_q))) |-> nmi_req);
  // R9: without a clear an active request persists
  p_req_persist_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && (clr_vec == '0)) |=> nmi_req);
  // R11: pin events stay quiet during a reconfiguration window
  p_cfg_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hold |-> !pin_evt);
  // R6: a filter tick only occurs with the filter on
  p_tick_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    filt_tick |-> cfg_q.filt_en);
endmodule

// File: tb/nmi_aggr_tb_top.sv
module nmi_aggr_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_in = 1'b1;
  logic       osc_stop_evt = 1'b0, wdt_err_evt = 1'b0, vmon1_evt = 1'b0, vmon2_evt = 1'b0;
  logic       cpu_ie = 1'b1;
  logic [3:0] cpu_ipl = 4'd0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [4:0] wr_data = 5'd0;
  logic [1:0] rd_addr = 2'd2;
  logic [4:0] rd_data;
  logic       nmi_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  nmi_aggr dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .osc_stop_evt(osc_stop_evt),
    .wdt_err_evt(wdt_err_evt), .vmon1_evt(vmon1_evt), .vmon2_evt(vmon2_evt),
    .cpu_ie(cpu_ie), .cpu_ipl(cpu_ipl), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .nmi_req(nmi_req));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [4:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 5'd0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a; #1; v = int'(rd_data);
  endtask

  task automatic pulse(input int src);
    case (src)
      1: osc_stop_evt = 1'b1;
      2: wdt_err_evt  = 1'b1;
      3: vmon1_evt    = 1'b1;
      default: vmon2_evt = 1'b1;
    endcase
  endtask

  task automatic drop_all();
    osc_stop_evt = 1'b0; wdt_err_evt = 1'b0; vmon1_evt = 1'b0; vmon2_evt = 1'b0;
  endtask

  function automatic int period(input int sel);
    if (sel == 0) return 1;
    if (sel == 1) return 8;
    if (sel == 2) return 32;
    return 64;
  endfunction

  // clocks from a pin change until the request rises, capped
  task automatic measure(input int cap, output int n);
    n = 0;
    while (n < cap) begin
      @(negedge clk); n++;
      if (nmi_req) break;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, n, d;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R2: reset state
    rd(2'd0, v); check("R2 enable after reset", v, 0);
    rd(2'd2, v); check("R2 status after reset", v, 0);
    check("R2 request after reset", int'(nmi_req), 0);

    // R1 / R2: event latches while disabled, no request
    pulse(1); cyc(1); drop_all(); cyc(2);
    rd(2'd2, v); check("R1 osc flag latched while disabled", v, 2);
    check("R2 no request while disabled", int'(nmi_req), 0);
    // R4: zero write keeps flag, one write clears
    wr(2'd1, 5'b00000); rd(2'd2, v); check("R4 zero write ignored", v, 2);
    wr(2'd1, 5'b00010); rd(2'd2, v); check("R4 clear", v, 0);
    rd(2'd1, v); check("R4 clear reg reads 0", v, 0);

    // R3: write-once enable
    wr(2'd0, 5'b00010); wr(2'd0, 5'b00000);
    rd(2'd0, v); check("R3 enable locked", v, 2);
    wr(2'd0, 5'b11101); rd(2'd0, v); check("R3 enable accumulates", v, 31);

    // Sweep non-pin sources
    for (int s = 1; s <= 4; s++) begin
      for (int m = 0; m < 2; m++) begin
        cpu_ie = m[0]; cpu_ipl = (m == 0) ? 4'hF : 4'h0;
        pulse(s); cyc(1); drop_all(); #1;
        rd(2'd2, v); check("R1 flag position", v, 1 << s);
        check("R8 request under CPU mask state", int'(nmi_req), 1);
        // R10: event and clear together
        pulse(s); wr(2'd1, 5'(1 << s)); drop_all(); #1;
        rd(2'd2, v); check("R10 event beats clear", v, 1 << s);
        // R9: second flag keeps request through first clear
        pulse((s % 4) + 1); cyc(1); drop_all();
        wr(2'd1, 5'(1 << s)); #1;
        check("R9 request held by other flag", int'(nmi_req), 1);
        wr(2'd1, 5'b11110); #1;
        check("R9 request falls when all cleared", int'(nmi_req), 0);
      end
    end
    cpu_ie = 1'b1; cpu_ipl = 4'd0;

    // R7: unfiltered falling edge
    pin_in = 1'b0; measure(10, n); check("R7 unfiltered latency", n, 2);
    pin_in = 1'b1; cyc(3); wr(2'd1, 5'b00001); cyc(1);
    // R5: rising sense
    wr(2'd3, 5'b00001); cyc(3);
    pin_in = 1'b0; cyc(4); rd(2'd2, v); check("R5 falling ignored in rising mode", v, 0);
    pin_in = 1'b1; measure(10, n); check("R5 rising latency", n, 2);
    wr(2'd1, 5'b00001); cyc(1);
    wr(2'd3, 5'b00000); cyc(3); wr(2'd1, 5'b00001); cyc(1);

    // R6: filter sweep
    for (int sel = 0; sel < 4; sel++) begin
      d = period(sel);
      wr(2'd3, 5'({sel[1:0], 2'b10})); cyc(3 * d + 4);
      pin_in = 1'b0; cyc(2); pin_in = 1'b1; cyc(3 * d + 4);
      rd(2'd2, v); check("R6 short pulse rejected", v, 0);
      pin_in = 1'b0; measure(3 * d + 10, n);
      check("R6 filtered latency not early", int'(n >= 2 * d + 2), 1);
      check("R6 filtered latency not late", int'(n <= 3 * d + 1), 1);
      pin_in = 1'b1; cyc(3 * d + 4); wr(2'd1, 5'b00001); cyc(1);
    end

    // R11: turning the filter off with pin already low
    wr(2'd3, 5'b01110); cyc(200);
    pin_in = 1'b0; cyc(20);
    wr(2'd3, 5'b00000); cyc(10);
    rd(2'd2, v); check("R11 no false edge on reconfig", v, 0);
    check("R11 request low after reconfig", int'(nmi_req), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule